// File: doc/BRIEF.md
# Triple-Buffer Frame Rate Converter

This block sits between a video producer and a video consumer that run at unrelated frame rates. Incoming 24-bit pixels arrive on a valid/ready stream, are collected in a small write FIFO and are written into external memory through a write master. A read master fetches frames back in bursts into a small read FIFO, and the pixels leave on a second valid/ready stream. The memory holds three frame-sized buffers. The writer fills one buffer and the reader drains another. The third buffer is a spare that is handed between the two sides at frame boundaries.

The two sides never use the same buffer. The reader shows a newly completed frame as soon as one is available, and otherwise shows its current frame again. The writer never overwrites a frame that has not been shown. Instead it withdraws ready until the reader has taken that frame. Memory traffic is paced by FIFO fill level against a burst target, and a partly filled write FIFO is also flushed at the end of each pixel line.

The frame size (H_PIX × V_LINES words) must be a multiple of BURST. FIFO_DEPTH must be a power of two and no smaller than BURST.

Top module: `triple_frame_buffer`

## Requirements
- R1: Buffer k (k = 0, 1, 2) starts at byte address BASE_ADDR + k × H_PIX × V_LINES × 4, with one 32-bit word per pixel and addresses rising by 4 per pixel within a frame. The writer and the reader never hold the same buffer index.
- R2: After reset the reader fetches from buffer 0, starting at BASE_ADDR, and the writer fills buffer 1. `in_ready` is 1, and `out_valid` and `wm_write` are 0.
- R3: When the reader has requested the last burst of a frame, it moves to the spare buffer if that buffer holds a completed frame not yet read. Otherwise it reads its current buffer again, which repeats that frame.
- R4: When the writer stores the last word of a frame, it switches to the spare buffer if that buffer's frame has already been read. Otherwise it holds `in_ready` and `wm_write` low until the reader has taken the spare.
- R5: Each memory word is {8'h00, pixel}. In the pixel, bits [7:0] are blue, bits [15:8] are green and bits [23:16] are red. The output stream returns the stored bits [23:0] unchanged.
- R6: The write master starts a run of writes once the write FIFO holds at least BURST pixels. The run continues until the FIFO is empty. With fewer than BURST pixels queued and no line end pending, no write is issued.
- R7: Accepting the last pixel of a line (pixel H_PIX of a line) starts a write run that empties the FIFO, whatever its fill level.
- R8: A read request for BURST words is raised when FIFO_DEPTH minus the words held minus the words still outstanding is at least BURST. `rm_burstcount` is always BURST. Held plus outstanding words never exceed FIFO_DEPTH.
- R9: While a request is stalled by waitrequest, it stays asserted with its address (and write data) unchanged.
- R10: Output pixels of a frame appear in ascending address order of their buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 24 | Input pixel, red high byte, blue low byte |
| wm_write | output | 1 | Write request |
| wm_address | output | ADDR_W | Write byte address |
| wm_writedata | output | 32 | Write data word |
| wm_waitrequest | input | 1 | Memory stalls the write request |
| rm_read | output | 1 | Read burst request |
| rm_address | output | ADDR_W | Read burst start byte address |
| rm_burstcount | output | $clog2(BURST+1) | Words per read burst |
| rm_waitrequest | input | 1 | Memory stalls the read request |
| rm_readdatavalid | input | 1 | Read data word returned |
| rm_readdata | input | 32 | Returned read data |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_pixel | output | 24 | Output pixel |

## Verification
The hardest state to reach is the writer hold. It needs a spare buffer with an unread frame while the writer completes yet another frame. The reader therefore has to stall mid-frame while two full frames are written. The bench holds `out_ready` low until the read FIFO and its outstanding requests fill to capacity inside a repeated frame of buffer 0. It then streams two complete frames in, and only afterwards releases the consumer. It then checks that frames come out in the order buffer 0, buffer 1, buffer 2, and that ready comes back.

// File: rtl/triple_frame_buffer.sv
module triple_frame_buffer #(
  parameter int H_PIX = 1024,
  parameter int V_LINES = 768,
  parameter int BURST = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [23:0]                in_pixel,
  output logic                       wm_write,
  output logic [ADDR_W-1:0]          wm_address,
  output logic [31:0]                wm_writedata,
  input  logic                       wm_waitrequest,
  output logic                       rm_read,
  output logic [ADDR_W-1:0]          rm_address,
  output logic [$clog2(BURST+1)-1:0] rm_burstcount,
  input  logic                       rm_waitrequest,
  input  logic                       rm_readdatavalid,
  input  logic [31:0]                rm_readdata,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [23:0]                out_pixel
);
  localparam int FRAME_WORDS = H_PIX * V_LINES;
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int WC_W = $clog2(FRAME_WORDS + 1);
  localparam int LC_W = $clog2(H_PIX + 1);
  localparam int F_W = $clog2(FIFO_DEPTH + 1);
  localparam int P_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int BC_W = $clog2(BURST + 1);

  function automatic logic [ADDR_W-1:0] buf_base(input logic [1:0] b);
    return BASE_ADDR + ADDR_W'(b) * ADDR_W'(FRAME_BYTES);
  endfunction

  logic [1:0] wr_buf, rd_buf;
  logic [2:0] fresh;
  logic [1:0] spare;
  assign spare = 2'd3 - wr_buf - rd_buf;

  // write side
  logic [23:0]     wq [FIFO_DEPTH];
  logic [P_W-1:0]  wq_wp, wq_rp;
  logic [F_W-1:0]  wq_fill, wq_fill_n;
  logic [LC_W-1:0] in_col;
  logic [WC_W-1:0] wcnt;
  logic flush, burst_on, wr_hold;
  logic push, line_end, active, wpop, frame_done, w_swap;

  assign in_ready   = (wq_fill != F_W'(FIFO_DEPTH)) && !wr_hold;
  assign push       = in_valid && in_ready;
  assign line_end   = push && (in_col == LC_W'(H_PIX - 1));
  assign active     = burst_on || (wq_fill >= F_W'(BURST)) || flush;
  assign wm_write   = active && (wq_fill != '0) && !wr_hold;
  assign wpop       = wm_write && !wm_waitrequest;
  assign frame_done = wpop && (wcnt == WC_W'(FRAME_WORDS - 1));
  assign w_swap     = (frame_done || wr_hold) && !fresh[spare];
  assign wq_fill_n  = wq_fill + F_W'(push) - F_W'(wpop);

  assign wm_address   = buf_base(wr_buf) + ADDR_W'({wcnt, 2'b00});
  assign wm_writedata = {8'h00, wq[wq_rp]};

  always_ff @(posedge clk)
    if (push) wq[wq_wp] <= in_pixel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq_wp <= '0; wq_rp <= '0; wq_fill <= '0;
      in_col <= '0; wcnt <= '0;
      flush <= 1'b0; burst_on <= 1'b0; wr_hold <= 1'b0;
    end else begin
      wq_fill <= wq_fill_n;
      if (push) begin
        wq_wp  <= wq_wp + 1'b1;
        in_col <= line_end ? '0 : in_col + 1'b1;
      end
      if (wpop) begin
        wq_rp <= wq_rp + 1'b1;
        wcnt  <= frame_done ? '0 : wcnt + 1'b1;
      end
      if (line_end) flush <= 1'b1;
      else if (wq_fill_n == '0) flush <= 1'b0;
      burst_on <= active && (wq_fill_n != '0);
      if (frame_done && fresh[spare]) wr_hold <= 1'b1;
      else if (w_swap) wr_hold <= 1'b0;
    end
  end

  // read side
  logic [23:0]     rq [FIFO_DEPTH];
  logic [P_W-1:0]  rq_wp, rq_rp;
  logic [F_W-1:0]  rq_fill, pend, rfree;
  logic [WC_W-1:0] rcnt;
  logic raccept, rlast, r_take, rpop;

  assign rfree         = F_W'(FIFO_DEPTH) - rq_fill - pend;
  assign rm_read       = rfree >= F_W'(BURST);
  assign rm_burstcount = BC_W'(BURST);
  assign rm_address    = buf_base(rd_buf) + ADDR_W'({rcnt, 2'b00});
  assign raccept       = rm_read && !rm_waitrequest;
  assign rlast         = raccept && (rcnt == WC_W'(FRAME_WORDS - BURST));
  assign r_take        = rlast && fresh[spare];
  assign out_valid     = rq_fill != '0;
  assign out_pixel     = rq[rq_rp];
  assign rpop          = out_valid && out_ready;

  always_ff @(posedge clk)
    if (rm_readdatavalid) rq[rq_wp] <= rm_readdata[23:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_wp <= '0; rq_rp <= '0; rq_fill <= '0; pend <= '0; rcnt <= '0;
    end else begin
      if (rm_readdatavalid) rq_wp <= rq_wp + 1'b1;
      if (rpop) rq_rp <= rq_rp + 1'b1;
      rq_fill <= rq_fill + F_W'(rm_readdatavalid) - F_W'(rpop);
      pend <= pend + (raccept ? F_W'(BURST) : '0) - F_W'(rm_readdatavalid);
      if (raccept) rcnt <= rlast ? '0 : rcnt + WC_W'(BURST);
    end
  end

  // buffer rotation: writer and reader swaps are mutually exclusive on fresh[spare]
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_buf <= 2'd1; rd_buf <= 2'd0; fresh <= '0;
    end else begin
      if (frame_done) fresh[wr_buf] <= 1'b1;
      if (w_swap) wr_buf <= spare;
      if (r_take) begin
        rd_buf <= spare;
        fresh[spare] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/triple_frame_buffer_chk.sv
module triple_frame_buffer_chk #(
  parameter int FIFO_DEPTH = 64,
  parameter int ADDR_W = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [1:0]                       wr_buf,
  input logic [1:0]                       rd_buf,
  input logic                             wr_hold,
  input logic                             in_ready,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  rq_fill,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  pend,
  input logic                             wm_write,
  input logic                             wm_waitrequest,
  input logic [ADDR_W-1:0]                wm_address,
  input logic [31:0]                      wm_writedata,
  input logic                             rm_read,
  input logic                             rm_waitrequest,
  input logic [ADDR_W-1:0]                rm_address
);
  p_distinct_bufs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf != rd_buf) && (wr_buf != 2'd3) && (rd_buf != 2'd3));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rq_fill) + 32'(pend)) <= FIFO_DEPTH);

  p_hold_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> (!in_ready && !wm_write));

  p_wr_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_write && wm_waitrequest) |=> (wm_write && $stable(wm_address) && $stable(wm_writedata)));

  p_rd_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_read && rm_waitrequest) |=> (rm_read && $stable(rm_address)));
endmodule

bind triple_frame_buffer triple_frame_buffer_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .rd_buf(rd_buf), .wr_hold(wr_hold),
  .in_ready(in_ready), .rq_fill(rq_fill), .pend(pend), .wm_write(wm_write),
  .wm_waitrequest(wm_waitrequest), .wm_address(wm_address), .wm_writedata(wm_writedata),
  .rm_read(rm_read), .rm_waitrequest(rm_waitrequest), .rm_address(rm_address)
);

// File: tb/triple_frame_buffer_bench.sv
module triple_frame_buffer_bench;
  localparam int H = 6, V = 2, BURST = 4, DEPTH = 8;
  localparam int FW = H * V;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [23:0] in_pixel = '0;
  logic wm_write, rm_read, out_valid, in_ready;
  logic [31:0] wm_address, wm_writedata, rm_address;
  logic [2:0] rm_burstcount;
  logic wm_waitrequest = 0, rm_waitrequest = 0, rm_readdatavalid = 0;
  logic [31:0] rm_readdata = '0;
  logic [23:0] out_pixel;

  always #5 clk = ~clk;

  triple_frame_buffer #(.H_PIX(H), .V_LINES(V), .BURST(BURST), .FIFO_DEPTH(DEPTH),
    .ADDR_W(32), .BASE_ADDR(BASE)) u_triple_frame_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .wm_write(wm_write), .wm_address(wm_address), .wm_writedata(wm_writedata),
    .wm_waitrequest(wm_waitrequest), .rm_read(rm_read), .rm_address(rm_address),
    .rm_burstcount(rm_burstcount), .rm_waitrequest(rm_waitrequest),
    .rm_readdatavalid(rm_readdatavalid), .rm_readdata(rm_readdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel));

  logic [31:0] mem [0:3*FW-1];
  int q [0:63];
  int qh = 0, qt = 0, cyc = 0;
  int wr_count = 0, rd_bursts = 0, got = 0;
  logic [31:0] waddr_log [0:63];
  logic [23:0] outq [0:127];
  int tests = 0, fails = 0;
  bit done = 0;

  // memory and stream model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    wm_waitrequest = rst_n && (cyc % 3 == 0);
    rm_waitrequest = rst_n && (cyc % 4 == 1);
    if (qh != qt) begin
      rm_readdatavalid = 1;
      rm_readdata = mem[q[qh % 64]];
      qh++;
    end else rm_readdatavalid = 0;
    if (rst_n && rm_read && !rm_waitrequest) begin
      rd_bursts++;
      for (int k = 0; k < BURST; k++) begin
        q[qt % 64] = int'((rm_address - BASE) >> 2) + k;
        qt++;
      end
    end
    if (rst_n && wm_write && !wm_waitrequest) begin
      mem[(wm_address - BASE) >> 2] = wm_writedata;
      waddr_log[wr_count % 64] = wm_address;
      wr_count++;
    end
    if (rst_n && out_valid && out_ready) begin
      outq[got % 128] = out_pixel;
      got++;
    end
  end

  function automatic logic [23:0] f1(int i); return 24'h112200 + 24'(i); endfunction
  function automatic logic [23:0] f2(int i); return 24'h334400 + 24'(i); endfunction
  function automatic logic [23:0] f0(int i); return 24'hA00000 + 24'(i); endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic send_px(input logic [23:0] px);
    @(posedge clk); #2;
    in_valid = 1; in_pixel = px;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3*FW; i++) mem[i] = (i < FW) ? {8'h00, f0(i)} : 32'h0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    #1;
    chk(in_ready == 1, "R2 in_ready after reset", 32'(in_ready), 1);
    chk(out_valid == 0 && wm_write == 0, "R2 idle outputs after reset", {out_valid, wm_write}, 0);
    chk(rm_read == 1 && rm_address == BASE, "R2 reader starts at buffer 0", rm_address, BASE);
    chk(rm_burstcount == 3'(BURST), "R8 burstcount", 32'(rm_burstcount), BURST);
  endtask

  task automatic t_read_pacing;
    settle(40);
    chk(rd_bursts == DEPTH / BURST, "R8 bursts limited by fifo space", rd_bursts, DEPTH / BURST);
    chk(rm_read == 0 && out_valid == 1, "R8 read held off when full", {rm_read, out_valid}, 1);
  endtask

  task automatic t_repeat;
    bit ok = 1;
    @(posedge clk); #2 out_ready = 1;
    do begin @(posedge clk); #2; end while (got < 2*FW);
    out_ready = 0;
    for (int i = 0; i < 2*FW; i++) if (outq[i] != f0(i % FW)) ok = 0;
    chk(ok, "R3 R10 frame of buffer 0 repeated in order", 32'(outq[FW]), 32'(f0(0)));
    chk(got == 2*FW, "R10 exact pop count", got, 2*FW);
  endtask

  task automatic t_threshold;
    for (int i = 0; i < 3; i++) send_px(f1(i));
    settle(10);
    chk(wr_count == 0, "R6 no write below burst target", wr_count, 0);
    send_px(f1(3));
    settle(10);
    chk(wr_count == 4, "R6 run drains fifo at target", wr_count, 4);
    chk(waddr_log[0] == BASE + 32'(FW*4), "R1 first frame goes to buffer 1", waddr_log[0], BASE + 32'(FW*4));
    chk(mem[FW] == {8'h00, f1(0)}, "R5 word packing", mem[FW], {8'h00, f1(0)});
    send_px(f1(4));
    settle(10);
    chk(wr_count == 4, "R6 single pixel stays queued", wr_count, 4);
    send_px(f1(5));
    settle(10);
    chk(wr_count == 6, "R7 line end flushes partial fifo", wr_count, 6);
  endtask

  task automatic t_frame1_rest;
    bit ok = 1;
    for (int i = 6; i < FW; i++) send_px(f1(i));
    settle(20);
    chk(wr_count == FW, "R6 frame 1 fully written", wr_count, FW);
    for (int i = 0; i < FW; i++) if (mem[FW + i] != {8'h00, f1(i)}) ok = 0;
    for (int i = 1; i < FW; i++) if (waddr_log[i] != waddr_log[i-1] + 4) ok = 0;
    chk(ok, "R1 R5 linear addresses and data in buffer 1", mem[FW + FW - 1], {8'h00, f1(FW-1)});
    chk(in_ready == 1, "R4 writer swaps to unread-free spare", 32'(in_ready), 1);
  endtask

  task automatic t_hold;
    bit ok = 1;
    for (int i = 0; i < FW; i++) send_px(f2(i));
    settle(30);
    chk(wr_count == 2*FW, "R4 frame 2 written", wr_count, 2*FW);
    for (int i = 0; i < FW; i++) if (mem[2*FW + i] != {8'h00, f2(i)}) ok = 0;
    chk(ok, "R1 frame 2 in buffer 2", mem[2*FW], {8'h00, f2(0)});
    chk(in_ready == 0, "R4 writer holds while spare unread", 32'(in_ready), 0);
    settle(20);
    chk(in_ready == 0 && wr_count == 2*FW, "R4 hold persists", 32'(in_ready), 0);
  endtask

  task automatic t_switch;
    bit ok0 = 1, ok1 = 1, ok2 = 1;
    @(posedge clk); #2 out_ready = 1;
    do begin @(posedge clk); #2; end while (got < 5*FW);
    out_ready = 0;
    for (int i = 0; i < FW; i++) begin
      if (outq[2*FW + i] != f0(i)) ok0 = 0;
      if (outq[3*FW + i] != f1(i)) ok1 = 0;
      if (outq[4*FW + i] != f2(i)) ok2 = 0;
    end
    chk(ok0, "R3 paused buffer 0 frame completes first", 32'(outq[2*FW]), 32'(f0(0)));
    chk(ok1, "R3 reader takes fresh buffer 1", 32'(outq[3*FW]), 32'(f1(0)));
    chk(ok2, "R3 reader then takes buffer 2", 32'(outq[4*FW]), 32'(f2(0)));
    chk(in_ready == 1, "R4 writer resumes after reader takes spare", 32'(in_ready), 1);
    for (int i = 0; i < BURST; i++) send_px(f1(i));
    settle(10);
    chk(waddr_log[2*FW] == BASE, "R1 third frame goes to buffer 0", waddr_log[2*FW], BASE);
  endtask

  initial begin
    t_reset();
    t_read_pacing();
    t_repeat();
    t_threshold();
    t_frame1_rest();
    t_hold();
    t_switch();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule